// File: doc/BRIEF.md
# Serial Flash Command Slave

This block is the device end of a small serial configuration memory reached over a four-wire SPI-style link (active-low select, serial clock, data in, data out). A host lowers the select and clocks in an opcode, then address and data bytes as the opcode calls for. For the read-type commands, the host then clocks data back out. All pins are oversampled by the block's own system clock, so the link clock is never used as a clock inside the block.

The storage is a behavioural byte array split into four equal sectors, chosen by the top two address bits. With `ADDR_BITS` = 17 the array holds 128 KB in four 32 KB sectors. The default is smaller so that the array stays cheap to elaborate. Any command that changes state takes effect only when the select is released on a whole byte. Such a command also needs the write-enable latch to be set. An internal write or erase holds the block busy for a set number of clocks. While it is busy, the block answers only the status read.

Top module: `sflash_slave`

## Requirements
- R1: Opcode, address and data bits travel MSB first. An input bit is taken on each rising `sck` while `cs_n` is low. An output bit changes on the falling `sck`. `sdo_oe` is 1 only during the output phase of an accepted read-type command with select low. `sdo` is 0 whenever `sdo_oe` is 0.
- R2: The opcodes are 0x06 latch set, 0x04 latch clear, 0x05 status read, 0x01 status write, 0x03 byte read, 0x02 byte write, 0xD8 sector erase, 0xC7 full erase and 0xAB identity read. Any other opcode causes no output and no state change until the select rises.
- R3: A status read returns the byte {user[5:0], latch, busy}, with busy in bit 0 and the write-enable latch in bit 1. The byte is sent again for every further 8 clocks, and each repeat is sampled anew.
- R4: An identity read returns the `DEVICE_ID` parameter, repeated for every further byte.
- R5: A byte read takes 3 address bytes, of which only the low `ADDR_BITS` bits are used. It then streams bytes from successive addresses, wrapping at the end of the array. The host may raise the select after any output bit, and the next command works normally.
- R6: 0x06 sets the write-enable latch and 0x04 clears it.
- R7: State-changing commands (0x06, 0x04, 0x01, 0x02, 0xD8, 0xC7) take effect only if the select rises after a whole multiple of 8 clocks and after all of their bytes. Otherwise nothing changes, the latch included.
- R8: A write, erase or status write with the latch clear has no effect. A committed one clears the latch and holds busy for `BUSY_CYCLES` clocks.
- R9: A byte write (0x02, 3 address bytes, data) ANDs its first data byte into the stored byte. Any further data bytes are ignored.
- R10: A sector erase (0xD8, 3 address bytes) sets every byte of the sector named by the top two address bits to 0xFF. A full erase (0xC7) sets the whole array to 0xFF.
- R11: A status write (0x01, data) loads data bits 7:2 into status bits 7:2. Bits 1:0 are not taken from the data.
- R12: While busy, every opcode except 0x05 is treated as unknown: reads give no output and modifying commands have no effect.
- R13: After reset the array holds 0xFF in every byte, the status byte is 0x00 and the output is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, 0 when not driven |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The busy counter running out and the reload of a status byte into the output shifter can fall on the same stretch of clocks. In that case the WIP bit of a byte depends on the cycle in which that byte was loaded. The bench provokes this by committing a write and then at once streaming a status read of many bytes, so the busy period ends partway through the stream. The stream passes if every byte is 0x01 or 0x00, it starts at 0x01, it ends at 0x00, and it never returns to 0x01 once it has read 0x00.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

   localparam logic [7:0] OPC_LATCH_SET = 8'h06;
   localparam logic [7:0] OPC_LATCH_CLR = 8'h04;
   localparam logic [7:0] OPC_STAT_RD   = 8'h05;
   localparam logic [7:0] OPC_STAT_WR   = 8'h01;
   localparam logic [7:0] OPC_MEM_RD    = 8'h03;
   localparam logic [7:0] OPC_MEM_WR    = 8'h02;
   localparam logic [7:0] OPC_SEC_WIPE  = 8'hD8;
   localparam logic [7:0] OPC_ALL_WIPE  = 8'hC7;
   localparam logic [7:0] OPC_IDENT     = 8'hAB;

   typedef enum logic [3:0] {
      C_NONE, C_WEN, C_WDIS, C_RSR, C_WSR, C_READ, C_WRITE, C_SERASE, C_BERASE, C_ID
   } cmd_e;

   typedef enum logic [2:0] {
      S_OPC, S_ADDR, S_DATA, S_OUT, S_HOLD, S_SKIP
   } phase_e;

   function automatic cmd_e decode_op(input logic [7:0] b);
      case (b)
         OPC_LATCH_SET: return C_WEN;
         OPC_LATCH_CLR: return C_WDIS;
         OPC_STAT_RD:   return C_RSR;
         OPC_STAT_WR:   return C_WSR;
         OPC_MEM_RD:    return C_READ;
         OPC_MEM_WR:    return C_WRITE;
         OPC_SEC_WIPE:  return C_SERASE;
         OPC_ALL_WIPE:  return C_BERASE;
         OPC_IDENT:     return C_ID;
         default:       return C_NONE;
      endcase
   endfunction

endpackage

// File: rtl/sfl_shifter.sv
module sfl_shifter #(
   parameter int SYNC_STAGES = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       sdi,
   input  logic       out_en,
   input  logic [7:0] tx_data,
   output logic       cs_s,
   output logic       cs_rise,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic       aligned,
   output logic       tx_take,
   output logic       sdo_bit
);

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sfl_shifter: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic [2:0] raw, syn;
   assign raw = {cs_n, sck, sdi};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign syn = raw;
      end else begin : g_sync
         logic [2:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= 3'b100;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign syn = stg[SYNC_STAGES-1];
      end
   endgenerate

   logic sck_s, sdi_s, cs_d, sck_d, rise, fall;
   assign {cs_s, sck_s, sdi_s} = syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   assign rise    = sck_s & ~sck_d & ~cs_s;
   assign fall    = ~sck_s & sck_d & ~cs_s;
   assign cs_rise = cs_s & ~cs_d;

   // receive side: bit counter modulo 8 and shift register
   logic [2:0] bit_cnt;
   logic [6:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         sh      <= '0;
      end else if (cs_s) begin
         bit_cnt <= '0;
      end else if (rise) begin
         sh      <= {sh[5:0], sdi_s};
         bit_cnt <= bit_cnt + 3'd1;
      end
   end

   assign byte_done = rise && (bit_cnt == 3'd7);
   assign rx_byte   = {sh, sdi_s};
   assign aligned   = (bit_cnt == 3'd0);

   // transmit side: reload every eighth falling edge
   logic [7:0] tx;
   logic [2:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx   <= '0;
         left <= '0;
      end else if (cs_s || !out_en) begin
         tx   <= '0;
         left <= '0;
      end else if (fall) begin
         if (left == 3'd0) begin
            tx   <= tx_data;
            left <= 3'd7;
         end else begin
            tx   <= {tx[6:0], 1'b0};
            left <= left - 3'd1;
         end
      end
   end

   assign tx_take = fall && out_en && (left == 3'd0);
   assign sdo_bit = tx[7];

   p_bits_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_s) |-> aligned);

endmodule

// File: rtl/sfl_busy.sv
module sfl_busy #(
   parameter int BUSY_CYCLES = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("sfl_busy: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(BUSY_CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   p_start_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   p_start_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

endmodule

// File: rtl/sfl_array.sv
module sfl_array #(
   parameter int ADDR_BITS = 11
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_BITS-1:0] rd_addr,
   output logic [7:0]           rd_data,
   input  logic                 we,
   input  logic [ADDR_BITS-1:0] wa,
   input  logic [7:0]           wd,
   input  logic                 erase_sec,
   input  logic                 erase_all,
   input  logic [1:0]           sec_sel
);

   localparam int NSEC      = 4;
   localparam int SEC_BITS  = ADDR_BITS - 2;
   localparam int SEC_DEPTH = 1 << SEC_BITS;

   generate
      if (ADDR_BITS < 4 || ADDR_BITS > 24) begin : g_bad_addr
         $error("sfl_array: ADDR_BITS must be 4..24");
      end
   endgenerate

   logic [7:0] rd_bank [NSEC];

   for (genvar s = 0; s < NSEC; s++) begin : g_sec
      logic [7:0] cells [SEC_DEPTH];
      logic hit_w, wipe;
      assign hit_w = we && (wa[ADDR_BITS-1:SEC_BITS] == 2'(s));
      assign wipe  = erase_all || (erase_sec && (sec_sel == 2'(s)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SEC_DEPTH; i++) cells[i] <= 8'hFF;
         end else if (wipe) begin
            for (int i = 0; i < SEC_DEPTH; i++) cells[i] <= 8'hFF;
         end else if (hit_w) begin
            cells[wa[SEC_BITS-1:0]] <= cells[wa[SEC_BITS-1:0]] & wd;
         end
      end

      assign rd_bank[s] = cells[rd_addr[SEC_BITS-1:0]];
   end

   assign rd_data = rd_bank[rd_addr[ADDR_BITS-1:SEC_BITS]];

   p_erase_excl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_sec || erase_all) |-> !we);

endmodule

// File: rtl/sflash_slave.sv
module sflash_slave
   import sfl_pkg::*;
#(
   parameter int         ADDR_BITS   = 11,
   parameter int         BUSY_CYCLES = 64,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] DEVICE_ID   = 8'h10
)(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe
);

   generate
      if (ADDR_BITS < 4 || ADDR_BITS > 24) begin : g_bad_top
         $error("sflash_slave: ADDR_BITS must be 4..24");
      end
   endgenerate

   logic       cs_s, cs_rise, byte_done, aligned, tx_take, sdo_bit, busy;
   logic [7:0] rx_byte, tx_data, rd_data;
   logic       out_en;

   phase_e               ph;
   cmd_e                 kind, dec, op_kind;
   logic [1:0]           abytes;
   logic [ADDR_BITS-1:0] addr;
   logic [ADDR_BITS+7:0] addr_cat;
   logic [7:0]           wdat;
   logic                 wel;
   logic [5:0]           sr_user;
   logic                 commit, mod, mem_we, wipe_sec, wipe_all;

   sfl_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .out_en(out_en), .tx_data(tx_data),
      .cs_s(cs_s), .cs_rise(cs_rise), .byte_done(byte_done), .rx_byte(rx_byte),
      .aligned(aligned), .tx_take(tx_take), .sdo_bit(sdo_bit)
   );

   sfl_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(mod), .busy(busy)
   );

   sfl_array #(.ADDR_BITS(ADDR_BITS)) u_array (
      .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_data(rd_data),
      .we(mem_we), .wa(addr), .wd(wdat),
      .erase_sec(wipe_sec), .erase_all(wipe_all),
      .sec_sel(addr[ADDR_BITS-1:ADDR_BITS-2])
   );

   // opcode decode; a busy array only answers the status read
   assign dec      = decode_op(rx_byte);
   assign op_kind  = (busy && dec != C_RSR) ? C_NONE : dec;
   assign addr_cat = {addr, rx_byte};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= S_OPC;
         kind   <= C_NONE;
         abytes <= '0;
         addr   <= '0;
         wdat   <= 8'hFF;
      end else if (cs_s) begin
         ph <= S_OPC;
      end else if (byte_done) begin
         case (ph)
            S_OPC: begin
               kind   <= op_kind;
               abytes <= '0;
               case (op_kind)
                  C_NONE:                     ph <= S_SKIP;
                  C_WEN, C_WDIS, C_BERASE:    ph <= S_HOLD;
                  C_RSR, C_ID:                ph <= S_OUT;
                  C_WSR:                      ph <= S_DATA;
                  default:                    ph <= S_ADDR;
               endcase
            end
            S_ADDR: begin
               addr   <= addr_cat[ADDR_BITS-1:0];
               abytes <= abytes + 2'd1;
               if (abytes == 2'd2) begin
                  if (kind == C_READ)       ph <= S_OUT;
                  else if (kind == C_WRITE) ph <= S_DATA;
                  else                      ph <= S_HOLD;
               end
            end
            S_DATA: begin
               wdat <= rx_byte;
               ph   <= S_HOLD;
            end
            default: ;
         endcase
      end else if (tx_take && kind == C_READ) begin
         addr <= addr + 1'b1;
      end
   end

   // commit on select release at a byte boundary once the command is whole
   assign commit   = cs_rise && (ph == S_HOLD) && aligned;
   assign mod      = commit && wel &&
                     (kind == C_WSR || kind == C_WRITE || kind == C_SERASE || kind == C_BERASE);
   assign mem_we   = mod && (kind == C_WRITE);
   assign wipe_sec = mod && (kind == C_SERASE);
   assign wipe_all = mod && (kind == C_BERASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel     <= 1'b0;
         sr_user <= '0;
      end else begin
         if (commit && kind == C_WEN)       wel <= 1'b1;
         else if (commit && kind == C_WDIS) wel <= 1'b0;
         else if (mod)                      wel <= 1'b0;
         if (mod && kind == C_WSR)          sr_user <= wdat[7:2];
      end
   end

   always_comb begin
      case (kind)
         C_RSR:   tx_data = {sr_user, wel, busy};
         C_ID:    tx_data = DEVICE_ID;
         C_READ:  tx_data = rd_data;
         default: tx_data = 8'h00;
      endcase
   end

   assign out_en = (ph == S_OUT);
   assign sdo_oe = out_en && !cs_s;
   assign sdo    = sdo_bit & sdo_oe;

   p_latch_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wel) |-> $past(cs_rise));
   p_no_change_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(mem_we || wipe_sec || wipe_all));
   p_latch_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || wipe_sec || wipe_all) |=> !wel);
   p_start_needs_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || wipe_sec || wipe_all) |-> wel);

endmodule

// File: tb/sflash_slave_test.sv
module sflash_slave_test;

   localparam int         AB   = 6;
   localparam int         NB   = 1 << AB;
   localparam int         BUSY = 800;
   localparam int         HALF = 5;
   localparam int         GAP  = 8;
   localparam logic [7:0] ID   = 8'hA5;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic sdo, sdo_oe;

   always #2 clk = ~clk;

   sflash_slave #(.ADDR_BITS(AB), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2), .DEVICE_ID(ID)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
   );

   int checks = 0, errors = 0, oe_hits = 0;
   logic [7:0] model [NB];
   logic [7:0] rbuf  [NB+8];
   logic [7:0] st;

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 29 + 7) ^ 8'h3C;
   endfunction

   task automatic wt(input int n); repeat (n) @(negedge clk); endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bitx(input logic b, output logic o);
      sdi = b; wt(HALF); o = sdo; if (sdo_oe) oe_hits++;
      sck = 1'b1; wt(HALF); sck = 1'b0;
   endtask

   task automatic bytex(input logic [7:0] v, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         logic o;
         bitx(v[i], o);
         r[i] = o;
      end
   endtask

   task automatic sel;   cs_n = 1'b0; wt(HALF); endtask
   task automatic desel; wt(HALF); cs_n = 1'b1; wt(GAP); endtask
   task automatic put(input logic [7:0] v); logic [7:0] d; bytex(v, d); endtask
   task automatic simple(input logic [7:0] op); sel(); put(op); desel(); endtask
   task automatic idle; wt(BUSY + 20); endtask

   task automatic rd_status(output logic [7:0] s);
      sel(); put(8'h05); bytex(8'h00, s); desel();
   endtask

   task automatic rd_mem(input int a, input int n);
      sel(); put(8'h03); put(8'h00); put(8'h00); put(a[7:0]);
      oe_hits = 0;
      for (int i = 0; i < n; i++) bytex(8'h00, rbuf[i]);
      desel();
   endtask

   task automatic wr_mem(input int a, input logic [7:0] d);
      sel(); put(8'h02); put(8'h00); put(8'h00); put(a[7:0]); put(d); desel();
   endtask

   task automatic cmp_all(input string req);
      rd_mem(0, NB);
      for (int i = 0; i < NB; i++) chk(req, rbuf[i], model[i]);
   endtask

   task automatic report;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic o;
      for (int i = 0; i < NB; i++) model[i] = 8'hFF;
      wt(5); rst_n = 1'b1; wt(5);

      // R13 reset state, R1 idle output
      chk("R13 oe idle", sdo_oe, 0);
      chk("R1 sdo idle", sdo, 0);
      rd_status(st); chk("R13 status after reset", st, 8'h00);
      cmp_all("R13 array erased");
      chk("R1 oe during output", oe_hits, NB * 8);
      wt(2); chk("R1 oe low after release", sdo_oe, 0);

      // R4 identity
      sel(); put(8'hAB); bytex(8'h00, rbuf[0]); bytex(8'h00, rbuf[1]); desel();
      chk("R4 id byte0", rbuf[0], ID); chk("R4 id byte1", rbuf[1], ID);

      // R6 latch set / clear, R3 status repeat
      simple(8'h06);
      sel(); put(8'h05);
      for (int i = 0; i < 3; i++) bytex(8'h00, rbuf[i]);
      desel();
      for (int i = 0; i < 3; i++) chk("R3 R6 status repeat latch set", rbuf[i], 8'h02);
      simple(8'h04); rd_status(st); chk("R6 latch cleared", st, 8'h00);

      // R7 boundary on latch-set
      sel(); put(8'h06); bitx(1'b0, o); desel();
      rd_status(st); chk("R7 latch set with extra bit rejected", st, 8'h00);
      sel(); put(8'h06); put(8'h00); desel();
      rd_status(st); chk("R7 latch set on 16 clocks accepted", st, 8'h02);
      simple(8'h04);

      // R8 write with latch clear
      wr_mem(5, 8'h00); idle();
      rd_mem(5, 1); chk("R8 write without latch", rbuf[0], 8'hFF);

      // R9 sweep of every address
      for (int a = 0; a < NB; a++) begin
         simple(8'h06); wr_mem(a, pat(a)); model[a] = model[a] & pat(a); idle();
      end
      cmp_all("R9 sweep write");
      rd_mem(NB - 2, 4);
      for (int i = 0; i < 4; i++) chk("R5 address wrap", rbuf[i], model[(NB - 2 + i) % NB]);

      // R9 AND of a second write, extra data bytes ignored
      simple(8'h06);
      sel(); put(8'h02); put(8'h00); put(8'h00); put(8'd20); put(8'h0F); put(8'h00); desel();
      model[20] = model[20] & 8'h0F; idle();
      rd_mem(20, 1); chk("R9 AND and extra bytes ignored", rbuf[0], model[20]);

      // R7 write ended off a byte boundary
      simple(8'h06);
      sel(); put(8'h02); put(8'h00); put(8'h00); put(8'd10); put(8'h00); bitx(1'b0, o); desel();
      rd_status(st); chk("R7 unaligned write keeps latch", st, 8'h02);
      rd_mem(10, 1); chk("R7 unaligned write no effect", rbuf[0], model[10]);
      simple(8'h04);

      // R12 busy: reads refused, status shows WIP
      simple(8'h06); wr_mem(30, 8'h81); model[30] = model[30] & 8'h81;
      rd_mem(30, 1);
      chk("R12 read refused while busy", rbuf[0], 8'h00);
      chk("R12 no output while busy", oe_hits, 0);
      rd_status(st); chk("R8 R12 status during busy", st, 8'h01);
      idle();
      rd_status(st); chk("R8 busy ended latch cleared", st, 8'h00);
      rd_mem(30, 1); chk("R9 data after busy", rbuf[0], model[30]);

      // R12 R3 busy expiry inside a status stream
      simple(8'h06); wr_mem(40, 8'h00); model[40] = 8'h00;
      sel(); put(8'h05);
      for (int i = 0; i < 14; i++) bytex(8'h00, rbuf[i]);
      desel();
      chk("R12 stream starts busy", rbuf[0], 8'h01);
      chk("R12 stream ends idle", rbuf[13], 8'h00);
      for (int i = 1; i < 14; i++) begin
         logic ok;
         ok = (rbuf[i] == 8'h00) || (rbuf[i] == 8'h01 && rbuf[i-1] == 8'h01);
         chk("R3 stream monotonic", ok, 1);
      end
      idle();

      // R11 status write
      simple(8'h06); sel(); put(8'h01); put(8'hFF); desel(); idle();
      rd_status(st); chk("R11 user bits set", st, 8'hFC);
      simple(8'h06); sel(); put(8'h01); put(8'h00); desel(); idle();
      rd_status(st); chk("R11 user bits cleared", st, 8'h00);

      // R10 sector erase of sector 2
      simple(8'h06);
      sel(); put(8'hD8); put(8'h00); put(8'h00); put(8'h25); desel(); idle();
      for (int i = 0; i < NB; i++) if ((i >> (AB - 2)) == 2) model[i] = 8'hFF;
      cmp_all("R10 sector erase");

      // R2 unknown opcode
      sel(); put(8'h9F); oe_hits = 0; put(8'h00); put(8'h00); desel();
      chk("R2 unknown gives no output", oe_hits, 0);
      rd_status(st); chk("R2 unknown no state change", st, 8'h00);

      // R5 read ended mid-byte, next command still works
      sel(); put(8'h03); put(8'h00); put(8'h00); put(8'h00); bitx(1'b0, o); bitx(1'b0, o); bitx(1'b0, o); desel();
      sel(); put(8'hAB); bytex(8'h00, rbuf[0]); desel();
      chk("R5 after partial read", rbuf[0], ID);

      // R8 full erase without latch, then R10 with latch
      simple(8'hC7); idle();
      rd_mem(0, 1); chk("R8 full erase without latch", rbuf[0], model[0]);
      simple(8'h06); simple(8'hC7); idle();
      for (int i = 0; i < NB; i++) model[i] = 8'hFF;
      cmp_all("R10 full erase");

      report();
   end

endmodule